// File: doc/BRIEF.md
# Edge-Armed Capture/Compare Timer

This block is a 16-bit up-counter for one combined capture and compare mode. After it is enabled it waits for a qualifying edge on the external timer input, and counting begins on that edge. Each qualifying edge after that copies the running count into a capture register, raises a one-cycle interrupt, sets a capture-cause flag and restarts the count at 1. If no edge arrives, the counter climbs to a programmed compare value. It then raises the interrupt, clears the flag and restarts at 1.

Software reaches the block through a byte-wide write port. The count advances once per prescaler tick, and the prescaler divides the system clock by a power of two. The timer input passes through a two-stage synchronizer before edge detection.

Register map: address 0 is control, with bit 0 enable, bit 1 polarity and bits 4:2 prescale exponent. Address 1 stages the count high byte and address 2 writes the count low byte. Address 3 stages the compare high byte and address 4 writes the compare low byte.

Top module: `capcmp_timer`

## Requirements
- R1: While enabled, the counter stays idle until the first qualifying input edge. No interrupt of either kind occurs before that edge.
- R2: Control bit 1 selects the qualifying edge: 0 means rising and 1 means falling. Edges of the other direction have no effect.
- R3: Once counting has started, each qualifying edge copies the current count into `cap_value`. The first capture after a start value C with edge spacing k cycles reads C + floor((k-1)/2^N).
- R4: A capture raises `irq` for one cycle, sets `cap_flag`, and restarts the count at 1. Later captures at spacing k read 1 + floor((k-1)/2^N).
- R5: With no edges, a tick at which the count equals the compare value raises `irq`, clears `cap_flag` and restarts the count at 1. The interrupt period is therefore compare × 2^N cycles.
- R6: Control bits 4:2 hold N, and the count advances once every 2^N clocks (N = 0..7). The prescaler restarts at each start or capture edge.
- R7: If a capture edge and a compare match fall on the same cycle, the capture wins. Exactly one interrupt pulse occurs, `cap_flag` is 1 and the captured value equals the compare value.
- R8: Clearing enable stops the counter and disarms it. After re-enabling, no interrupt occurs until a new first edge.
- R9: A 16-bit register takes its new value only when its low byte is written. A lone high-byte write leaves the value in use unchanged.
- R10: After reset, `irq`, `cap_flag` and `cap_value` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Write data byte |
| tmr_in | input | 1 | Asynchronous timer input |
| cap_value | output | 16 | Last captured count |
| irq | output | 1 | One-cycle interrupt pulse |
| cap_flag | output | 1 | 1 when the last interrupt came from a capture |

## Verification
A wrong count or prescaler state shows at the next interrupt. It appears either as a captured value that departs from C + floor((k-1)/2^N), or as a compare interval different from compare × 2^N cycles. A stuck run state shows within one compare period: interrupts appear while the timer is disarmed, or no interrupt ever follows the start edge. A wrong priority or flag update shows as two pulses, or as a wrong flag, on the cycle where an edge lands on a compare match.

// File: rtl/capcmp_timer.sv
module capcmp_timer #(
  parameter int BW = 8,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [BW-1:0] wr_data,
  input  logic          tmr_in,
  output logic [2*BW-1:0] cap_value,
  output logic          irq,
  output logic          cap_flag
);
  localparam int CW  = 2 * BW;
  localparam int PDW = (1 << PW) - 1;

  logic          en, pol, run;
  logic [PW-1:0] psc;
  logic [BW-1:0] cnt_hi_st, cmp_hi_st;
  logic [CW-1:0] cnt, cmp;
  logic [PDW-1:0] pre;
  logic          s1, s2, s3;

  logic [PDW:0]   span, span_m1;
  logic [PDW-1:0] tmask;
  logic           tick, hit, cnt_wr;

  assign span    = {{PDW{1'b0}}, 1'b1} << psc;
  assign span_m1 = span - 1'b1;
  assign tmask   = span_m1[PDW-1:0];
  assign tick    = (pre & tmask) == tmask;
  assign hit     = pol ? (s3 & ~s2) : (~s3 & s2);
  assign cnt_wr  = wr_en && (wr_addr == 3'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s1, s2, s3} <= '0;
      en <= 1'b0; pol <= 1'b0; psc <= '0; run <= 1'b0;
      cnt_hi_st <= '0; cmp_hi_st <= '0;
      cnt <= '0; cmp <= '0; pre <= '0;
      cap_value <= '0; irq <= 1'b0; cap_flag <= 1'b0;
    end else begin
      s1 <= tmr_in; s2 <= s1; s3 <= s2;
      irq <= 1'b0;
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin en <= wr_data[0]; pol <= wr_data[1]; psc <= wr_data[2 +: PW]; end
          3'd1: cnt_hi_st <= wr_data;
          3'd3: cmp_hi_st <= wr_data;
          3'd4: cmp <= {cmp_hi_st, wr_data};
          default: ;
        endcase
      end
      if (cnt_wr) cnt <= {cnt_hi_st, wr_data};
      if (!en) begin
        run <= 1'b0;
        pre <= '0;
      end else if (!run) begin
        if (hit) begin
          run <= 1'b1;
          pre <= '0;
        end
      end else if (hit) begin
        cap_value <= cnt;
        cnt       <= CW'(1);
        irq       <= 1'b1;
        cap_flag  <= 1'b1;
        pre       <= '0;
      end else begin
        pre <= pre + 1'b1;
        if (tick) begin
          if (cnt == cmp) begin
            cnt      <= CW'(1);
            irq      <= 1'b1;
            cap_flag <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !irq);
  p_cap_with_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_value) |-> (irq && cap_flag));
  p_restart_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt == CW'(1)));
  p_flag_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_flag) |-> irq);
  p_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !run);
endmodule

// File: tb/capcmp_timer_tb.sv
module capcmp_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        tmr_in = 1'b0;
  logic [15:0] cap_value;
  logic        irq, cap_flag;

  int nvec = 0, nbad = 0, cyc = 0, ncap = 0;
  logic        cur_pol = 1'b0;
  logic [15:0] caps  [0:15];
  logic        flags [0:15];
  int          times [0:15];

  always #4 clk = ~clk;

  capcmp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tmr_in(tmr_in), .cap_value(cap_value), .irq(irq), .cap_flag(cap_flag)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && irq) begin
      if (ncap < 16) begin
        caps[ncap]  = cap_value;
        flags[ncap] = cap_flag;
        times[ncap] = cyc;
      end
      ncap = ncap + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic p, input logic [2:0] n, input logic [15:0] c, input logic [15:0] m);
    wr(3'd0, {6'b0, p, 1'b0});
    cur_pol = p; tmr_in = p;
    idle(4);
    wr(3'd1, c[15:8]); wr(3'd2, c[7:0]);
    wr(3'd3, m[15:8]); wr(3'd4, m[7:0]);
    wr(3'd0, {3'b0, n, p, 1'b1});
    ncap = 0;
  endtask

  task automatic edge_gap(input int k);
    @(negedge clk); tmr_in = ~cur_pol;
    @(negedge clk); tmr_in = cur_pol;
    repeat (k - 2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    idle(3);
    chk(irq == 1'b0 && cap_flag == 1'b0 && cap_value == 16'd0, "R10 reset", int'(cap_value), 0);
    rst_n = 1'b1;
    idle(2);

    // R1: armed but idle, no compare interrupt before the first edge
    setup(1'b0, 3'd0, 16'd1, 16'd3);
    idle(40);
    chk(ncap == 0, "R1 idle before edge", ncap, 0);
    edge_gap(2);
    idle(20);
    chk(ncap > 0, "R1 counting after edge", ncap, 1);

    // R2 R3 R4 R6: capture sweep over polarity, prescale and edge spacing
    for (int p = 0; p < 2; p++)
      for (int n = 0; n < 4; n++)
        for (int ki = 0; ki < 4; ki++) begin
          int k;
          k = (ki == 0) ? 2 : (ki == 1) ? 3 : (ki == 2) ? 6 : 11;
          setup(1'(p), 3'(n), 16'h0100, 16'hFFFF);
          edge_gap(k); edge_gap(k); edge_gap(k); edge_gap(k);
          idle(6);
          chk(ncap == 3, "R2 capture count", ncap, 3);
          if (ncap == 3) begin
            chk(caps[0] == 16'(32'h0100 + ((k - 1) >> n)), "R3 first capture",
                int'(caps[0]), 32'h0100 + ((k - 1) >> n));
            chk(caps[1] == 16'(1 + ((k - 1) >> n)), "R4 restart capture",
                int'(caps[1]), 1 + ((k - 1) >> n));
            chk(caps[2] == 16'(1 + ((k - 1) >> n)), "R6 prescaled capture",
                int'(caps[2]), 1 + ((k - 1) >> n));
            chk(flags[0] && flags[1] && flags[2], "R4 flag set", int'(flags[2]), 1);
            chk(times[1] - times[0] == k, "R3 capture spacing", times[1] - times[0], k);
          end
        end

    // R5 R6: compare period sweep
    for (int n = 0; n < 3; n++)
      for (int mi = 0; mi < 3; mi++) begin
        int m;
        m = (mi == 0) ? 1 : (mi == 1) ? 2 : 5;
        setup(1'b0, 3'(n), 16'd1, 16'(m));
        edge_gap(2);
        idle(4 * (m << n) + 10);
        chk(ncap >= 3, "R5 compare count", ncap, 3);
        if (ncap >= 3) begin
          chk(times[1] - times[0] == (m << n), "R5 compare period", times[1] - times[0], m << n);
          chk(times[2] - times[1] == (m << n), "R6 compare period", times[2] - times[1], m << n);
          chk(!flags[0] && !flags[1] && !flags[2], "R5 flag clear", int'(flags[1]), 0);
        end
      end

    // R7: edge on the same tick as a compare match
    setup(1'b0, 3'd0, 16'd1, 16'd5);
    edge_gap(5);
    edge_gap(5);
    idle(2);
    chk(ncap == 1, "R7 single pulse", ncap, 1);
    chk(caps[0] == 16'd5, "R7 captured value", int'(caps[0]), 5);
    chk(flags[0] == 1'b1, "R7 flag", int'(flags[0]), 1);

    // R8: disable disarms
    setup(1'b0, 3'd0, 16'd1, 16'd4);
    edge_gap(3);
    wr(3'd0, 8'h00);
    idle(2);
    ncap = 0;
    edge_gap(3); edge_gap(3);
    idle(10);
    chk(ncap == 0, "R8 disabled quiet", ncap, 0);
    wr(3'd0, 8'h01);
    idle(30);
    chk(ncap == 0, "R8 re-enable waits", ncap, 0);
    edge_gap(2);
    idle(20);
    chk(ncap > 0, "R8 restart on edge", ncap, 1);

    // R9: lone high-byte write does not disturb the count
    setup(1'b0, 3'd0, 16'h1234, 16'hFFFF);
    wr(3'd1, 8'hAB);
    edge_gap(7);
    edge_gap(7);
    idle(5);
    chk(ncap == 1 && caps[0] == 16'h123A, "R9 staged write", int'(caps[0]), 32'h123A);

    finish_run();
  end
endmodule